// File: doc/BRIEF.md
# Linear CCD Drive Timing Generator

This block derives every digital drive waveform of a three-colour linear CCD sensor from one fast system clock. The sensor has separate odd and even output registers for each colour. Each line opens with a charge-transfer window. The shift clocks freeze around it, and all colour gates pulse together. A readout phase follows. In readout the two-phase shift clocks alternate once per pixel, and the reset gate and clamp pulses repeat at a fixed offset inside every pixel period.

Two clamp schemes are supported. In bit clamp, the clamp pulse follows the reset pulse in every pixel, and both keep running through the transfer window. In line clamp, the reset gate is held high across the whole transfer window, and the clamp output is the inverse of the transfer gate. A line-start strobe marks each line. A region tag tells downstream logic where the current pixel sits in the line map.

The pixel period is set in system-clock cycles, as are the reset and clamp widths. The guard gaps, the transfer width and the readout length are set in pixel periods. All drive outputs come from flops and reflect the internal sequencer one cycle later.

Top module: `ccd_line_timer`

## Requirements
- R1: While rst_ni is low, sh2_o is 1. All other outputs are 0, and region_o reads 0.
- R2: A line runs in four phases, each counted in pixel periods: a guard gap of G periods, a transfer window of T periods, a second guard gap of G periods, then readout. During both gaps and the transfer window, sh1_o and sh_last_o are 1 and sh2_o is 0.
- R3: All xfer_o bits are equal. They are 1 exactly during the T transfer periods of each line, and the first line after reset starts with this sequence.
- R4: In readout, sh1_o is 1 on even pixel indexes (counted from 0) and 0 on odd ones. sh2_o is always the complement of sh1_o, and sh_last_o always equals sh1_o.
- R5: Every pixel period is P system cycles. rg_o is 1 for the first RW cycles of each period in readout, and in every phase when bit clamp is in effect.
- R6: In bit clamp (mode 0), clamp_o is 1 for CW cycles starting right after the reset pulse ends. This holds in every pixel period, including the transfer window and the gaps.
- R7: In line clamp (mode 1), rg_o is held at 1 through both gaps and the transfer window, and clamp_o is the inverse of the transfer gate.
- R8: mode_i is sampled only in the first cycle of a line. A change at any other time takes effect at the next line start.
- R9: region_o encodes 0 = dummy, 1 = optical black, 2 = invalid, 3 = valid. In readout the pixel index maps, in order, to N_DUM dummy, N_OB optical black, N_INV invalid, N_VALID valid and N_INV invalid pixels, and any further pixels are dummy. Outside readout the tag is 0.
- R10: Degenerate settings are raised to safe minimums: P below 2 acts as 2, G or T of 0 acts as 1, and a readout length below N_DUM+N_OB+2*N_INV+N_VALID acts as that sum. The line period is therefore (2G+T+L)*P cycles with these effective values.
- R11: line_start_o is a one-cycle pulse in the first cycle of each line, at the start of the first guard gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Clamp scheme: 0 bit clamp, 1 line clamp |
| cfg_pix_cyc_i | input | CYC_W | Pixel period P in system cycles |
| cfg_rg_w_i | input | CYC_W | Reset pulse width RW in cycles |
| cfg_cl_w_i | input | CYC_W | Clamp pulse width CW in cycles |
| cfg_gap_i | input | GAP_W | Guard gap G in pixel periods |
| cfg_xfer_i | input | GAP_W | Transfer width T in pixel periods |
| cfg_line_i | input | PIX_W | Readout length L in pixels |
| sh1_o | output | 1 | Shift clock phase 1 |
| sh2_o | output | 1 | Shift clock phase 2 |
| sh_last_o | output | 1 | Last-stage shift clock |
| rg_o | output | 1 | Reset gate pulse |
| clamp_o | output | 1 | Reset-level clamp pulse |
| xfer_o | output | N_COLOR | Transfer gate, one per colour |
| line_start_o | output | 1 | Line-start strobe |
| region_o | output | 2 | Pixel region tag |

## Verification
The risky coincidence is a clamp-mode change arriving in the same cycle as a line start. The sampled value must then govern the whole line, while a change one cycle later must wait a full line. The bench flips mode_i exactly in the line-start cycle in one directed run, and at random cycles in the others. Its model latches the mode only at the cycle it computes as a line start, and judges rg_o and clamp_o cycle by cycle against that latched value. The transfer window is a second meeting point, because in bit clamp the per-pixel pulses overlap the frozen shift clocks there. Each cycle of that window is therefore checked on all outputs together.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_XFER  = 2'd1,
    PH_HOLD  = 2'd2,
    PH_READ  = 2'd3
  } line_ph_e;

  typedef enum logic [1:0] {
    REG_DUMMY   = 2'd0,
    REG_OB      = 2'd1,
    REG_INVALID = 2'd2,
    REG_VALID   = 2'd3
  } region_e;
endpackage

// File: rtl/ccd_tg_seq.sv
module ccd_tg_seq
  import ccd_tg_pkg::*;
#(
  parameter int CYC_W    = 8,
  parameter int GAP_W    = 10,
  parameter int PIX_W    = 14,
  parameter int LINE_MIN = 7440
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CYC_W-1:0] cfg_pix_cyc_i,
  input  logic [GAP_W-1:0] cfg_gap_i,
  input  logic [GAP_W-1:0] cfg_xfer_i,
  input  logic [PIX_W-1:0] cfg_line_i,
  input  logic             mode_i,
  output line_ph_e         phase_o,
  output logic [CYC_W-1:0] sub_o,
  output logic [PIX_W-1:0] cnt_o,
  output logic             first_o,
  output logic             mode_o
);
  localparam logic [PIX_W-1:0] LINE_MIN_W = PIX_W'(LINE_MIN);

  line_ph_e         phase_q, phase_nx;
  logic [CYC_W-1:0] sub_q, pcyc_eff;
  logic [PIX_W-1:0] cnt_q, gap_eff, xfer_eff, line_eff, lim;
  logic             mode_q, tick, phase_end, first;

  assign pcyc_eff = (cfg_pix_cyc_i < CYC_W'(2)) ? CYC_W'(2) : cfg_pix_cyc_i;
  assign gap_eff  = (cfg_gap_i == '0) ? PIX_W'(1) : PIX_W'(cfg_gap_i);
  assign xfer_eff = (cfg_xfer_i == '0) ? PIX_W'(1) : PIX_W'(cfg_xfer_i);
  assign line_eff = (cfg_line_i < LINE_MIN_W) ? LINE_MIN_W : cfg_line_i;

  always_comb begin
    case (phase_q)
      PH_SETUP: begin lim = gap_eff;  phase_nx = PH_XFER;  end
      PH_XFER:  begin lim = xfer_eff; phase_nx = PH_HOLD;  end
      PH_HOLD:  begin lim = gap_eff;  phase_nx = PH_READ;  end
      default:  begin lim = line_eff; phase_nx = PH_SETUP; end
    endcase
  end

  // >= keeps the counters recoverable if a setting shrinks mid-line
  assign tick      = sub_q >= (pcyc_eff - CYC_W'(1));
  assign phase_end = cnt_q >= (lim - PIX_W'(1));
  assign first     = (phase_q == PH_SETUP) && (cnt_q == '0) && (sub_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q   <= '0;
      cnt_q   <= '0;
      phase_q <= PH_SETUP;
      mode_q  <= 1'b0;
    end else begin
      sub_q <= tick ? '0 : sub_q + CYC_W'(1);
      if (tick) begin
        if (phase_end) begin
          cnt_q   <= '0;
          phase_q <= phase_nx;
        end else begin
          cnt_q <= cnt_q + PIX_W'(1);
        end
      end
      if (first) mode_q <= mode_i;
    end
  end

  assign phase_o = phase_q;
  assign sub_o   = sub_q;
  assign cnt_o   = cnt_q;
  assign first_o = first;
  assign mode_o  = first ? mode_i : mode_q;

  assert_sub_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_q < pcyc_eff);
  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < lim);
  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !first |=> $stable(mode_q));
endmodule

// File: rtl/ccd_tg_pulse.sv
module ccd_tg_pulse #(
  parameter int CYC_W = 8
) (
  input  logic [CYC_W-1:0] sub_i,
  input  logic [CYC_W-1:0] rg_w_i,
  input  logic [CYC_W-1:0] cl_w_i,
  output logic             rg_o,
  output logic             cl_o
);
  logic [CYC_W:0] sub_x, rg_end, cl_end;

  assign sub_x  = {1'b0, sub_i};
  assign rg_end = {1'b0, rg_w_i};
  assign cl_end = rg_end + {1'b0, cl_w_i};
  assign rg_o   = sub_x < rg_end;
  assign cl_o   = (sub_x >= rg_end) && (sub_x < cl_end);
endmodule

// File: rtl/ccd_tg_region.sv
module ccd_tg_region
  import ccd_tg_pkg::*;
#(
  parameter int PIX_W   = 14,
  parameter int N_DUM   = 32,
  parameter int N_OB    = 96,
  parameter int N_INV   = 6,
  parameter int N_VALID = 7300
) (
  input  logic             in_read_i,
  input  logic [PIX_W-1:0] pix_i,
  output region_e          region_o
);
  localparam int B_OB  = N_DUM;
  localparam int B_IV0 = B_OB + N_OB;
  localparam int B_VAL = B_IV0 + N_INV;
  localparam int B_IV1 = B_VAL + N_VALID;
  localparam int B_END = B_IV1 + N_INV;

  always_comb begin
    if (!in_read_i)                     region_o = REG_DUMMY;
    else if (pix_i < PIX_W'(B_OB))      region_o = REG_DUMMY;
    else if (pix_i < PIX_W'(B_IV0))     region_o = REG_OB;
    else if (pix_i < PIX_W'(B_VAL))     region_o = REG_INVALID;
    else if (pix_i < PIX_W'(B_IV1))     region_o = REG_VALID;
    else if (pix_i < PIX_W'(B_END))     region_o = REG_INVALID;
    else                                region_o = REG_DUMMY;
  end
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_tg_pkg::*;
#(
  parameter int N_COLOR = 3,
  parameter int CYC_W   = 8,
  parameter int GAP_W   = 10,
  parameter int PIX_W   = 14,
  parameter int N_DUM   = 32,
  parameter int N_OB    = 96,
  parameter int N_INV   = 6,
  parameter int N_VALID = 7300
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic [CYC_W-1:0]   cfg_pix_cyc_i,
  input  logic [CYC_W-1:0]   cfg_rg_w_i,
  input  logic [CYC_W-1:0]   cfg_cl_w_i,
  input  logic [GAP_W-1:0]   cfg_gap_i,
  input  logic [GAP_W-1:0]   cfg_xfer_i,
  input  logic [PIX_W-1:0]   cfg_line_i,
  output logic               sh1_o,
  output logic               sh2_o,
  output logic               sh_last_o,
  output logic               rg_o,
  output logic               clamp_o,
  output logic [N_COLOR-1:0] xfer_o,
  output logic               line_start_o,
  output logic [1:0]         region_o
);
  localparam int LINE_MIN = N_DUM + N_OB + 2 * N_INV + N_VALID;

  line_ph_e         phase;
  logic [CYC_W-1:0] sub;
  logic [PIX_W-1:0] pix;
  logic             first, mode_eff, rg_bit, cl_bit;
  logic             in_read, in_xfer, sh1_d, rg_d, cl_d;
  region_e          reg_d, reg_q;
  logic             sh1_q, sh2_q, rg_q, cl_q, xfer_q, strobe_q;

  ccd_tg_seq #(
    .CYC_W(CYC_W), .GAP_W(GAP_W), .PIX_W(PIX_W), .LINE_MIN(LINE_MIN)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_pix_cyc_i(cfg_pix_cyc_i), .cfg_gap_i(cfg_gap_i),
    .cfg_xfer_i(cfg_xfer_i), .cfg_line_i(cfg_line_i), .mode_i(mode_i),
    .phase_o(phase), .sub_o(sub), .cnt_o(pix), .first_o(first), .mode_o(mode_eff)
  );

  ccd_tg_pulse #(.CYC_W(CYC_W)) u_pulse (
    .sub_i(sub), .rg_w_i(cfg_rg_w_i), .cl_w_i(cfg_cl_w_i),
    .rg_o(rg_bit), .cl_o(cl_bit)
  );

  ccd_tg_region #(
    .PIX_W(PIX_W), .N_DUM(N_DUM), .N_OB(N_OB), .N_INV(N_INV), .N_VALID(N_VALID)
  ) u_region (
    .in_read_i(in_read), .pix_i(pix), .region_o(reg_d)
  );

  assign in_read = (phase == PH_READ);
  assign in_xfer = (phase == PH_XFER);
  // phase 1 parks high while the transfer gates move charge
  assign sh1_d   = in_read ? ~pix[0] : 1'b1;
  assign rg_d    = (mode_eff && !in_read) ? 1'b1 : rg_bit;
  assign cl_d    = mode_eff ? !in_xfer : cl_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh1_q    <= 1'b0;
      sh2_q    <= 1'b1;
      rg_q     <= 1'b0;
      cl_q     <= 1'b0;
      xfer_q   <= 1'b0;
      strobe_q <= 1'b0;
      reg_q    <= REG_DUMMY;
    end else begin
      sh1_q    <= sh1_d;
      sh2_q    <= ~sh1_d;
      rg_q     <= rg_d;
      cl_q     <= cl_d;
      xfer_q   <= in_xfer;
      strobe_q <= first;
      reg_q    <= reg_d;
    end
  end

  for (genvar g = 0; g < N_COLOR; g++) begin : g_xfer
    assign xfer_o[g] = xfer_q;
  end

  assign sh1_o        = sh1_q;
  assign sh2_o        = sh2_q;
  assign sh_last_o    = sh1_q;
  assign rg_o         = rg_q;
  assign clamp_o      = cl_q;
  assign line_start_o = strobe_q;
  assign region_o     = reg_q;

  assert_xfer_static_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_q |-> (sh1_q && !sh2_q));
  assert_strobe_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |=> !strobe_q);
  assert_line_rg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_eff && !in_read) |=> rg_q);
  assert_bit_clamp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_eff |=> !(rg_q && cl_q));
  assert_region_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_q != REG_DUMMY) |-> $past(in_read));
endmodule

// File: tb/ccd_line_timer_tb.sv
`timescale 1ns/1ps
module ccd_line_timer_tb;
  localparam int CYC_W = 6, GAP_W = 6, PIX_W = 8;
  localparam int N_DUM = 2, N_OB = 4, N_INV = 2, N_VALID = 10;
  localparam int LMIN = N_DUM + N_OB + 2 * N_INV + N_VALID;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_i = 1'b0;
  logic [CYC_W-1:0] cfg_pix_cyc_i = '0, cfg_rg_w_i = '0, cfg_cl_w_i = '0;
  logic [GAP_W-1:0] cfg_gap_i = '0, cfg_xfer_i = '0;
  logic [PIX_W-1:0] cfg_line_i = '0;
  logic sh1_o, sh2_o, sh_last_o, rg_o, clamp_o, line_start_o;
  logic [2:0] xfer_o;
  logic [1:0] region_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ccd_line_timer #(
    .N_COLOR(3), .CYC_W(CYC_W), .GAP_W(GAP_W), .PIX_W(PIX_W),
    .N_DUM(N_DUM), .N_OB(N_OB), .N_INV(N_INV), .N_VALID(N_VALID)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i),
    .cfg_pix_cyc_i(cfg_pix_cyc_i), .cfg_rg_w_i(cfg_rg_w_i), .cfg_cl_w_i(cfg_cl_w_i),
    .cfg_gap_i(cfg_gap_i), .cfg_xfer_i(cfg_xfer_i), .cfg_line_i(cfg_line_i),
    .sh1_o(sh1_o), .sh2_o(sh2_o), .sh_last_o(sh_last_o), .rg_o(rg_o),
    .clamp_o(clamp_o), .xfer_o(xfer_o), .line_start_o(line_start_o), .region_o(region_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R9 map
  function automatic int exp_region(input bit rd, input int pix);
    if (!rd) return 0;
    if (pix < N_DUM) return 0;
    if (pix < N_DUM + N_OB) return 1;
    if (pix < N_DUM + N_OB + N_INV) return 2;
    if (pix < N_DUM + N_OB + N_INV + N_VALID) return 3;
    if (pix < LMIN) return 2;
    return 0;
  endfunction

  task automatic run_cfg(input int p, input int rw, input int cw, input int g,
                         input int t, input int l, input bit m0, input int lines,
                         input int flip_pct, input bit flip_at_start);
    int pe, ge, te, le, lp, period, ncyc, prev_n;
    bit line_mode, mode_prev;
    @(negedge clk);
    rst_ni = 1'b0;
    cfg_pix_cyc_i = CYC_W'(p); cfg_rg_w_i = CYC_W'(rw); cfg_cl_w_i = CYC_W'(cw);
    cfg_gap_i = GAP_W'(g); cfg_xfer_i = GAP_W'(t); cfg_line_i = PIX_W'(l);
    mode_i = m0;
    repeat (2) @(negedge clk);
    chk("R1", "sh1", sh1_o, 0);
    chk("R1", "sh2", sh2_o, 1);
    chk("R1", "last", sh_last_o, 0);
    chk("R1", "rg", rg_o, 0);
    chk("R1", "clamp", clamp_o, 0);
    chk("R1", "xfer", xfer_o, 0);
    chk("R1", "strobe", line_start_o, 0);
    chk("R1", "region", region_o, 0);
    // R10 effective settings
    pe = max_i(p, 2); ge = max_i(g, 1); te = max_i(t, 1); le = max_i(l, LMIN);
    lp = 2 * ge + te + le;
    period = lp * pe;
    ncyc = period * lines + 3;
    rst_ni = 1'b1;
    mode_prev = mode_i;
    line_mode = 1'b0;
    prev_n = -1;
    for (int n = 1; n <= ncyc; n++) begin
      int j, q, s, lq, pix, e_sh1, e_rg, e_cl;
      bit st, rd, xf, rgb, clb;
      string t_sh, t_rg, t_cl;
      @(negedge clk);
      j = n - 1; q = j / pe; s = j % pe; lq = q % lp;
      st = (lq == 0) && (s == 0);
      if (st) line_mode = mode_prev;
      rd = (lq >= 2 * ge + te);
      xf = (lq >= ge) && (lq < ge + te);
      pix = lq - 2 * ge - te;
      rgb = (s < rw);
      clb = (s >= rw) && (s < rw + cw);
      e_sh1 = rd ? ((pix % 2) == 0) : 1;
      e_rg = (line_mode && !rd) ? 1 : rgb;
      e_cl = line_mode ? !xf : clb;
      t_sh = rd ? "R4" : "R2";
      t_rg = (mode_prev != line_mode) ? "R8" : ((line_mode && !rd) ? "R7" : "R5");
      t_cl = (mode_prev != line_mode) ? "R8" : (line_mode ? "R7" : "R6");
      chk(t_sh, "sh1", sh1_o, e_sh1);
      chk(t_sh, "sh2", sh2_o, !e_sh1);
      chk("R4", "last", sh_last_o, e_sh1);
      chk("R3", "xfer", xfer_o, xf ? 7 : 0);
      chk(t_rg, "rg", rg_o, e_rg);
      chk(t_cl, "clamp", clamp_o, e_cl);
      chk("R11", "strobe", line_start_o, st);
      chk("R9", "region", region_o, exp_region(rd, pix));
      if (line_start_o) begin
        if (prev_n >= 0) chk("R10", "line period", n - prev_n, period);
        prev_n = n;
      end
      // drive mode for cycle n; a line start falls on n % period == 0
      if (flip_at_start && (n % period == 0)) mode_i = ~mode_i;
      else if (int'($urandom_range(99)) < flip_pct) mode_i = ~mode_i;
      mode_prev = mode_i;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R10 degenerate settings
    run_cfg(1, 1, 1, 0, 0, 5, 1'b0, 3, 0, 1'b0);
    // bit clamp, no mode changes
    run_cfg(4, 1, 2, 2, 3, 24, 1'b0, 3, 0, 1'b0);
    // line clamp throughout
    run_cfg(5, 2, 2, 2, 2, 21, 1'b1, 3, 0, 1'b0);
    // R8 mode flips exactly at line starts
    run_cfg(3, 1, 1, 1, 2, 20, 1'b0, 4, 0, 1'b1);
    // R8 mode flips mid-line
    run_cfg(2, 1, 1, 1, 1, 22, 1'b1, 4, 5, 1'b0);
    for (int k = 0; k < 8; k++) begin
      int p, rw, cw;
      p  = int'($urandom_range(6, 2));
      rw = int'($urandom_range(p, 1));
      cw = int'($urandom_range(3, 0));
      run_cfg(p, rw, cw, int'($urandom_range(3, 1)), int'($urandom_range(4, 1)),
              int'($urandom_range(40, 0)), 1'($urandom_range(1)), 3, 3, 1'b0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule